// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block drives an external successive-approximation converter core through its full operating cycle: power-on standby, a settling wait, software-triggered launch, the conversion handshake and the end-of-conversion event. Software talks to it through a small write/read register port holding a control word and a channel selection. The block tells the core which channel to sample and at which resolution, issues a one-cycle launch pulse, and waits for the core's one-cycle completion pulse carrying the sample.

Two mode choices are independent of each other. Single-channel versus group scanning picks how many channels one pass covers. One-pass versus repeating picks whether passes continue while the start bit stays set. A separate enable bit powers the sequencer up into standby. A start request is held pending until a settling interval of one microsecond, counted in clock cycles, has expired.

States: `S_OFF` (disabled), `S_STABILIZE` (settling count running), `S_STANDBY` (ready, idle), `S_LAUNCH` (launch pulse to the core), `S_WAIT_DONE` (awaiting completion). Transitions:
- OFF→STABILIZE when the enable bit is set.
- STABILIZE→STANDBY when the count expires.
- STANDBY→LAUNCH when the start bit is set.
- LAUNCH→WAIT_DONE unconditionally.
- WAIT_DONE→LAUNCH on completion when the pass has more channels, or when the pass ended in repeating mode with start still set.
- WAIT_DONE→STANDBY on completion otherwise.
- Any state→OFF when the enable bit is clear.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset all register fields read 0, `conv_start` and `eoc` are 0. Setting the enable bit alone never produces a `conv_start` pulse.
- R2: No `conv_start` occurs earlier than STAB_CYC = CLK_MHZ clock cycles after the enable bit is written. A start written together with the enable is held and launches within a few cycles after the wait expires.
- R3: A set start bit in standby produces a `conv_start` pulse exactly one cycle wide, with `conv_chan` giving the channel.
- R4: In single-channel one-pass mode, exactly one conversion of the selected channel takes place, and the start bit then reads back 0 by itself.
- R5: In scan mode one pass converts four valid channels in order. The pass begins at the selected channel; the step after 14 is 16 and the step after 26 is 0. Each new pass restarts at the selected channel.
- R6: In repeating mode, conversions continue while the start bit stays 1, and the start bit is not cleared by the block. After software clears start, the conversion in flight ends and no further launches follow.
- R7: The channel register (address 1, bits [4:0]) accepts only 0–14 and 16–26. Writes of any other value leave it unchanged.
- R8: With the resolution bit set, `result` equals the core's 10-bit sample. With it clear, `result` is {2'b00, sample[9:2]}.
- R9: Each completed conversion gives a one-cycle `eoc` pulse, the cycle after `conv_done`. In that same cycle `result` and `result_chan` are valid.
- R10: Clearing the enable bit at any time returns the block to OFF, clears start, and suppresses `eoc` for a completion that arrives afterwards.
- R11: A control write (address 0) with the enable bit 0 stores start as 0. Control bit positions: [0] enable, [1] start, [2] scan, [3] repeating, [4] 10-bit resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 channel |
| wr_data | input | 5 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 channel |
| rd_data | output | 5 | Read data for rd_addr |
| conv_start | output | 1 | One-cycle launch pulse to the converter core |
| conv_chan | output | 5 | Channel to convert |
| conv_res10 | output | 1 | Resolution request to the core (1 = 10-bit) |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_data | input | 10 | Sample from the core, valid with conv_done |
| eoc | output | 1 | End-of-conversion pulse |
| result | output | 10 | Converted value, resolution-adjusted |
| result_chan | output | 5 | Channel that result belongs to |

## Verification
The hardest situation to reach is an abort that races an in-flight conversion. The enable bit must fall after the launch pulse but before the core's completion pulse arrives. The bench's converter stub answers a fixed number of cycles after each launch. The bench watches for the launch pulse and clears the enable bit at once, so the late completion lands while the block is already off. A start request pending through the settling wait is the other delicate case. It is reached by writing enable and start in one control word and counting cycles to the first launch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    parameter int CH_W    = 5;
    parameter int DATA_W  = 10;
    parameter int LOW_W   = 8;
    parameter int REG_W   = 5;
    parameter int MAX_CH  = 26;
    parameter int HOLE_CH = 15;

    // control word bit positions
    parameter int CB_EN    = 0;
    parameter int CB_START = 1;
    parameter int CB_SCAN  = 2;
    parameter int CB_SEQ   = 3;
    parameter int CB_RES10 = 4;

    typedef enum logic [2:0] {
        S_OFF,
        S_STABILIZE,
        S_STANDBY,
        S_LAUNCH,
        S_WAIT_DONE
    } seq_state_t;

    function automatic logic ch_valid(input logic [CH_W-1:0] c);
        return (int'(c) <= MAX_CH) && (int'(c) != HOLE_CH);
    endfunction

    function automatic logic [CH_W-1:0] ch_next(input logic [CH_W-1:0] c);
        logic [CH_W-1:0] n;
        if (int'(c) >= MAX_CH)
            n = '0;
        else if (int'(c) == HOLE_CH - 1)
            n = CH_W'(HOLE_CH + 1);
        else
            n = c + CH_W'(1);
        return n;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    input  logic             clr_start,
    output logic [REG_W-1:0] rd_data,
    output logic             en_q,
    output logic             start_q,
    output logic             scan_q,
    output logic             seq_q,
    output logic             res10_q,
    output logic [CH_W-1:0]  sel_ch_q
);

    logic wr_ctrl;
    logic wr_chan;

    assign wr_ctrl = wr_en && !wr_addr;
    assign wr_chan = wr_en &&  wr_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
            scan_q  <= 1'b0;
            seq_q   <= 1'b0;
            res10_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q    <= wr_data[CB_EN];
            start_q <= wr_data[CB_START] & wr_data[CB_EN];
            scan_q  <= wr_data[CB_SCAN];
            seq_q   <= wr_data[CB_SEQ];
            res10_q <= wr_data[CB_RES10];
        end else if (clr_start || !en_q) begin
            start_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_ch_q <= '0;
        else if (wr_chan && ch_valid(wr_data[CH_W-1:0]))
            sel_ch_q <= wr_data[CH_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr) begin
            rd_data[CH_W-1:0] = sel_ch_q;
        end else begin
            rd_data[CB_EN]    = en_q;
            rd_data[CB_START] = start_q;
            rd_data[CB_SCAN]  = scan_q;
            rd_data[CB_SEQ]   = seq_q;
            rd_data[CB_RES10] = res10_q;
        end
    end

endmodule

// File: rtl/adc_seq_stab.sv
module adc_seq_stab #(
    parameter int CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (arm)
            cnt_q <= CW'(CYCLES - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
    import adc_seq_pkg::*;
#(
    parameter int GROUP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            adv,
    input  logic            scan,
    input  logic [CH_W-1:0] sel_ch,
    output logic [CH_W-1:0] cur_ch,
    output logic            last
);

    localparam int IW = (GROUP > 1) ? $clog2(GROUP) : 1;

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch <= '0;
            idx_q  <= '0;
        end else if (load) begin
            cur_ch <= sel_ch;
            idx_q  <= '0;
        end else if (adv) begin
            cur_ch <= ch_next(cur_ch);
            idx_q  <= idx_q + IW'(1);
        end
    end

    assign last = !scan || (idx_q == IW'(GROUP - 1));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       start,
    input  logic       seq,
    input  logic       stab_expired,
    input  logic       conv_done,
    input  logic       last,
    output seq_state_t state,
    output logic       stab_arm,
    output logic       chan_load,
    output logic       chan_adv,
    output logic       launch,
    output logic       capture,
    output logic       clr_start
);

    seq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = S_OFF;
        end else begin
            unique case (state)
                S_OFF:       nxt = S_STABILIZE;
                S_STABILIZE: if (stab_expired) nxt = S_STANDBY;
                S_STANDBY:   if (start) nxt = S_LAUNCH;
                S_LAUNCH:    nxt = S_WAIT_DONE;
                S_WAIT_DONE: begin
                    if (conv_done) begin
                        if (!last || (seq && start))
                            nxt = S_LAUNCH;
                        else
                            nxt = S_STANDBY;
                    end
                end
                default:     nxt = S_OFF;
            endcase
        end
    end

    always_comb begin
        stab_arm  = 1'b0;
        chan_load = 1'b0;
        chan_adv  = 1'b0;
        launch    = 1'b0;
        capture   = 1'b0;
        clr_start = 1'b0;
        if (en) begin
            unique case (state)
                S_OFF:       stab_arm = 1'b1;
                S_STABILIZE: ;
                S_STANDBY:   chan_load = start;
                S_LAUNCH:    launch = 1'b1;
                S_WAIT_DONE: begin
                    if (conv_done) begin
                        capture = 1'b1;
                        if (!last)
                            chan_adv = 1'b1;
                        else if (seq && start)
                            chan_load = 1'b1;
                        else
                            clr_start = !seq;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CLK_MHZ = 250,
    parameter int GROUP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic              conv_res10,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              eoc,
    output logic [DATA_W-1:0] result,
    output logic [CH_W-1:0]   result_chan
);

    localparam int STAB_CYC = (CLK_MHZ < 1) ? 1 : CLK_MHZ;
    localparam int PAD_W    = DATA_W - LOW_W;

    logic            en_q, start_q, scan_q, seq_q, res10_q;
    logic [CH_W-1:0] sel_ch_q;
    logic [CH_W-1:0] cur_ch;
    logic            last;
    logic            stab_expired;
    logic            stab_arm, chan_load, chan_adv, launch, capture, clr_start;
    seq_state_t      state;

    adc_seq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .clr_start (clr_start),
        .rd_data   (rd_data),
        .en_q      (en_q),
        .start_q   (start_q),
        .scan_q    (scan_q),
        .seq_q     (seq_q),
        .res10_q   (res10_q),
        .sel_ch_q  (sel_ch_q)
    );

    adc_seq_stab #(.CYCLES(STAB_CYC)) u_stab (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (stab_arm),
        .expired (stab_expired)
    );

    adc_seq_chan #(.GROUP(GROUP)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (chan_load),
        .adv    (chan_adv),
        .scan   (scan_q),
        .sel_ch (sel_ch_q),
        .cur_ch (cur_ch),
        .last   (last)
    );

    adc_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en_q),
        .start        (start_q),
        .seq          (seq_q),
        .stab_expired (stab_expired),
        .conv_done    (conv_done),
        .last         (last),
        .state        (state),
        .stab_arm     (stab_arm),
        .chan_load    (chan_load),
        .chan_adv     (chan_adv),
        .launch       (launch),
        .capture      (capture),
        .clr_start    (clr_start)
    );

    assign conv_start = launch;
    assign conv_chan  = cur_ch;
    assign conv_res10 = res10_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc         <= 1'b0;
            result      <= '0;
            result_chan <= '0;
        end else begin
            eoc <= capture;
            if (capture) begin
                result_chan <= cur_ch;
                if (res10_q)
                    result <= conv_data;
                else
                    result <= {{PAD_W{1'b0}}, conv_data[DATA_W-1:PAD_W]};
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            en_q,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_chan,
    input logic            conv_done,
    input logic            eoc,
    input logic            stab_expired
);

    AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R3

    AST_LAUNCH_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> stab_expired); // R2

    AST_LAUNCH_CHAN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ch_valid(conv_chan)); // R5

    AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc); // R9

    AST_EOC_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> $past(conv_done)); // R9

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_q) |-> (!conv_start && !eoc)); // R10

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_q         (en_q),
    .conv_start   (conv_start),
    .conv_chan    (conv_chan),
    .conv_done    (conv_done),
    .eoc          (eoc),
    .stab_expired (stab_expired)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
    import adc_seq_pkg::*;

    localparam int STAB = 250;
    localparam int LAT  = 5;
    localparam int NVEC = 6;
    // {res10, scan, channel}
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 5'd3},
        {1'b0, 1'b0, 5'd26},
        {1'b1, 1'b1, 5'd0},
        {1'b1, 1'b1, 5'd13},
        {1'b0, 1'b1, 5'd25},
        {1'b1, 1'b0, 5'd16}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_addr = 1'b0;
    logic [REG_W-1:0]  wr_data = '0;
    logic              rd_addr = 1'b0;
    logic [REG_W-1:0]  rd_data;
    logic              conv_start;
    logic [CH_W-1:0]   conv_chan;
    logic              conv_res10;
    logic              conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic              eoc;
    logic [DATA_W-1:0] result;
    logic [CH_W-1:0]   result_chan;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.CLK_MHZ(STAB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_res10(conv_res10),
        .conv_done(conv_done), .conv_data(conv_data), .eoc(eoc),
        .result(result), .result_chan(result_chan)
    );

    function automatic logic [DATA_W-1:0] mk_data(input logic [CH_W-1:0] c);
        return DATA_W'(int'(c) * 32 + 21);
    endfunction

    function automatic int exp_res(input logic [CH_W-1:0] c, input logic r10);
        return r10 ? int'(mk_data(c)) : int'(mk_data(c)) >> 2;
    endfunction

    function automatic logic [CH_W-1:0] nv(input logic [CH_W-1:0] c);
        if (c == 5'd14) return 5'd16;
        if (c == 5'd26) return 5'd0;
        return c + 5'd1;
    endfunction

    // converter stub: completion LAT cycles after launch
    int              stub_cnt = 0;
    logic [CH_W-1:0] stub_ch = '0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            stub_cnt <= LAT;
            stub_ch  <= conv_chan;
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= mk_data(stub_ch);
            end
        end
    end

    // monitors
    int   ev_n = 0;
    int   starts_n = 0;
    int   eoc_long = 0;
    int   ev_ch  [0:127];
    int   ev_res [0:127];
    logic prev_eoc = 1'b0;
    always @(negedge clk) begin
        if (conv_start) starts_n = starts_n + 1;
        if (eoc) begin
            if (ev_n < 128) begin
                ev_ch[ev_n]  = int'(result_chan);
                ev_res[ev_n] = int'(result);
            end
            ev_n = ev_n + 1;
            if (prev_eoc) eoc_long = eoc_long + 1;
        end
        prev_eoc = eoc;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [REG_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic a, output logic [REG_W-1:0] v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [REG_W-1:0] v;
        int base, s0, cyc, nexp;
        logic [CH_W-1:0] ch;

        // reset state (R1)
        tick(3);
        chk(conv_start == 1'b0, "R1 reset conv_start", int'(conv_start), 0);
        chk(eoc == 1'b0, "R1 reset eoc", int'(eoc), 0);
        rst_n = 1'b1;
        rd(1'b0, v); chk(v == 0, "R1 reset control", int'(v), 0);
        rd(1'b1, v); chk(v == 0, "R1 reset channel", int'(v), 0);

        // start without enable is not stored (R11)
        wr(1'b0, 5'b00010);
        rd(1'b0, v); chk(v == 0, "R11 start without enable", int'(v), 0);

        // invalid channel writes ignored (R7)
        wr(1'b1, 5'd15);
        rd(1'b1, v); chk(v == 0, "R7 channel 15 ignored", int'(v), 0);
        wr(1'b1, 5'd27);
        rd(1'b1, v); chk(v == 0, "R7 channel 27 ignored", int'(v), 0);
        wr(1'b1, 5'd16);
        rd(1'b1, v); chk(v == 16, "R7 channel 16 accepted", int'(v), 16);

        // enable alone launches nothing (R1)
        wr(1'b0, 5'b00001);
        tick(400);
        chk(starts_n == 0, "R1 no launch from enable", starts_n, 0);

        // vector table: one-pass operations (R3 R4 R5 R8 R9)
        for (int k = 0; k < NVEC; k++) begin
            base = ev_n;
            s0   = starts_n;
            wr(1'b1, VEC[k][4:0]);
            wr(1'b0, {VEC[k][6], 1'b0, VEC[k][5], 1'b1, 1'b1});
            for (int t = 0; t < 300; t++) begin
                rd(1'b0, v);
                if (!v[CB_START]) break;
            end
            tick(3);
            chk(v[CB_START] == 1'b0, "R4 start self-clears", int'(v[CB_START]), 0);
            nexp = VEC[k][5] ? 4 : 1;
            chk(ev_n - base == nexp, "R5 conversions per pass", ev_n - base, nexp);
            chk(starts_n - s0 == nexp, "R3 launches per pass", starts_n - s0, nexp);
            ch = VEC[k][4:0];
            for (int j = 0; j < nexp; j++) begin
                chk(ev_ch[base+j] == int'(ch), "R5 channel order", ev_ch[base+j], int'(ch));
                chk(ev_res[base+j] == exp_res(ch, VEC[k][6]), "R8 result value",
                    ev_res[base+j], exp_res(ch, VEC[k][6]));
                ch = nv(ch);
            end
        end

        // repeating mode (R6)
        base = ev_n;
        wr(1'b1, 5'd7);
        wr(1'b0, 5'b01011);
        for (int t = 0; t < 500; t++) begin
            if (ev_n - base >= 3) break;
            tick(1);
        end
        chk(ev_n - base >= 3, "R6 repeats while start set", ev_n - base, 3);
        rd(1'b0, v);
        chk(v[CB_START] == 1'b1, "R6 start held in repeat", int'(v[CB_START]), 1);
        for (int j = 0; j < 3; j++)
            chk(ev_ch[base+j] == 7, "R6 repeat channel", ev_ch[base+j], 7);
        wr(1'b0, 5'b01001);
        tick(30);
        base = ev_n;
        s0   = starts_n;
        tick(60);
        chk(ev_n == base, "R6 no eoc after start cleared", ev_n - base, 0);
        chk(starts_n == s0, "R6 no launch after start cleared", starts_n - s0, 0);

        // abort with completion in flight (R10)
        base = ev_n;
        s0   = starts_n;
        wr(1'b0, 5'b00011);
        for (int t = 0; t < 50; t++) begin
            if (starts_n != s0) break;
            tick(1);
        end
        wr(1'b0, 5'b00000);
        tick(20);
        chk(ev_n == base, "R10 no eoc after abort", ev_n - base, 0);
        rd(1'b0, v); chk(v == 0, "R10 control after abort", int'(v), 0);

        // pending start across the settling wait (R2)
        s0 = starts_n;
        wr(1'b0, 5'b00011);
        cyc = 0;
        while (starts_n == s0 && cyc < 400) begin
            tick(1);
            cyc++;
        end
        chk(cyc >= STAB, "R2 not before settle", cyc, STAB);
        chk(cyc <= STAB + 6, "R2 pending start honoured", cyc, STAB + 6);
        tick(20);
        chk(eoc_long == 0, "R9 eoc single cycle", eoc_long, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule